// File: doc/BRIEF.md
# I2C Slave Bridge to a 32-bit Register Bank

This block lets a host on a two-wire I2C bus read and write a bank of 32-bit registers. It watches the bus for start and stop conditions, answers to one 7-bit slave address, takes a one-byte register word address, then moves whole 32-bit words in either direction with the most significant byte first. Bursts advance the word address automatically and wrap from 0xFF to 0x00.

On the register side the bridge drives a plain parallel interface. A write strobe carries a complete word together with its address. A read-start strobe asks the register bank to present a word, which the bridge latches whole in that same clock cycle. A read-commit strobe tells the bank that the host has really taken the word. The bank uses this to apply side effects such as clear-on-read. A word is committed only when every part of it is known to be good, so partial writes and abandoned reads leave the registers untouched.

Both bus lines pass through a synchronizer before any decision is made. SDA is driven open-drain through an active-high pull-low enable that only changes while SCL is low.

Top module: `i2c_word_bridge`

## Requirements
- R1: After reset the SDA pull-low enable is 0 and none of the write, read-start or read-commit strobes is asserted.
- R2: A control byte whose upper 7 bits equal SLAVE_ADDR is acknowledged, and its bit 0 selects the direction (0 = write, 1 = read). With any other address the byte gets no acknowledge, and SDA is not pulled low and no strobe fires until the next start or stop.
- R3: In a write, the byte after the control byte is the register word address. Each following group of 4 bytes forms one word, most significant byte first. Every byte is acknowledged, and one write strobe carries the whole word after its 32nd bit.
- R4: After every completed written word the word address goes up by one, wrapping from 0xFF to 0x00. This includes the last word, so a later read that sends no address starts at the next register.
- R5: A start or stop that arrives before all 32 bits of a word are in drops that word with no write strobe, and leaves the word address unchanged.
- R6: A read is a write-direction control byte and an address byte, then a repeated start and a read-direction control byte. Data then leaves most significant byte first from the addressed register.
- R7: The whole 32-bit value is latched once per word, when that word's first bit is about to be sent. Changes to the register after that do not alter any of the word's four bytes.
- R8: The read-commit strobe fires exactly once per word, when the host acknowledges the third byte. The fourth byte still carries the latched original value.
- R9: If the host does not acknowledge any of the first three bytes, or a start or stop arrives before that point, no read-commit is issued. A host non-acknowledge ends the read, and SDA is released.
- R10: In a burst read the word address goes up by one after each committed word, wrapping from 0xFF to 0x00, and the next word is latched from the new address.
- R11: The SDA pull-low enable only becomes active while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| reg_addr | output | 8 | Register word address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 32 | Write data, valid while reg_wr is 1 |
| reg_rd_start | output | 1 | One-cycle strobe; reg_rdata is latched in this cycle |
| reg_rdata | input | 32 | Read data of the register at reg_addr |
| reg_rd_commit | output | 1 | One-cycle strobe: host has taken the word at reg_addr |

## Verification
The bench targets these corner cases:
- Abandoned words. A write cut short by a stop, or by a repeated start, must leave the register as it was. The word address must also stay put, so the following read returns the old value of the same register. A bridge that wrote early, or kept a stale byte count, would corrupt the register or read the wrong one.
- Clear-on-read registers. A read must return the original value in all four bytes, and the register must read back zero afterwards. A host non-acknowledge on the first or third byte must leave the register intact. A bridge that committed at the wrong acknowledge would lose data or fail to clear.
- Snapshots. A register value is changed in the middle of a word, and a design that did not latch the whole word shows mixed bytes.
- Address wrap and follow-on reads. Bursts that cross 0xFF, and reads that send no address after a write, expose a wrong increment or wrap.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_WADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= RST_VAL;
      else        chain_q <= din;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_word_bridge.sv
module i2c_word_bridge
  import i2c_word_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h2A,
  parameter int         DATA_W      = 32,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [7:0]        reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd_start,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rd_commit
);
  localparam int ADDR_W = 8;
  localparam int BYTES  = DATA_W / 8;
  localparam int BCW    = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [BCW-1:0] LAST_B   = BCW'(BYTES - 1);
  localparam logic [BCW-1:0] COMMIT_B = BCW'(BYTES - 2);

  logic rst_sn, scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  // reset: asserted asynchronously, released through two flops
  i2c_line_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_sn));
  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst_n(rst_sn), .din(scl_i), .dout(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_sn), .din(sda_i), .dout(sda_s));
  i2c_bus_events u_ev (
    .clk(clk), .rst_n(rst_sn), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  phase_e             ph_q, ph_n;
  logic [3:0]         bit_q, bit_n;
  logic [BCW-1:0]     byte_q, byte_n;
  logic [6:0]         sh_q, sh_n;
  logic [DATA_W-1:0]  word_q, word_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic               oe_q, oe_n, ackgo_q, ackgo_n, rw_q, rw_n;
  logic [7:0]         byte_v;

  assign byte_v = {sh_q, sda_s};

  always_comb begin
    ph_n = ph_q; bit_n = bit_q; byte_n = byte_q; sh_n = sh_q;
    word_n = word_q; addr_n = addr_q; oe_n = oe_q;
    ackgo_n = ackgo_q; rw_n = rw_q;
    reg_wr = 1'b0; reg_rd_start = 1'b0; reg_rd_commit = 1'b0;
    if (start_det || stop_det) begin
      // R5 R9: any unexpected condition abandons the current word
      ph_n   = start_det ? PH_CTRL : PH_IDLE;
      bit_n  = '0;
      byte_n = '0;
      oe_n   = 1'b0;
    end else if (scl_rise) begin
      unique case (ph_q)
        PH_CTRL, PH_WADDR, PH_WDATA: begin
          if (bit_q != 4'd8) begin
            sh_n  = byte_v[6:0];
            bit_n = bit_q + 4'd1;
            if (bit_q == 4'd7) begin
              ackgo_n = 1'b1;
              if (ph_q == PH_CTRL) begin          // R2
                ackgo_n = (byte_v[7:1] == SLAVE_ADDR);
                rw_n    = byte_v[0];
              end else if (ph_q == PH_WADDR) begin
                addr_n = byte_v;
              end else begin                      // R3 R4
                word_n = {word_q[DATA_W-9:0], byte_v};
                if (byte_q == LAST_B) begin
                  reg_wr = 1'b1;
                  addr_n = addr_q + 1'b1;
                  byte_n = '0;
                end else begin
                  byte_n = byte_q + 1'b1;
                end
              end
            end
          end else begin
            bit_n = '0;
            if (ph_q == PH_CTRL) begin
              if (!ackgo_q)  ph_n = PH_SKIP;
              else if (rw_q) begin                // R6 R7
                ph_n         = PH_RDATA;
                reg_rd_start = 1'b1;
                word_n       = reg_rdata;
                byte_n       = '0;
              end else       ph_n = PH_WADDR;
            end else if (ph_q == PH_WADDR) begin
              ph_n   = PH_WDATA;
              byte_n = '0;
            end
          end
        end
        PH_RDATA: begin
          if (bit_q != 4'd8) begin
            bit_n = bit_q + 4'd1;
          end else begin
            bit_n = '0;
            if (sda_s) begin
              ph_n = PH_SKIP;                     // R9
            end else begin
              if (byte_q == COMMIT_B) begin       // R8 R10
                reg_rd_commit = 1'b1;
                addr_n        = addr_q + 1'b1;
              end
              if (byte_q == LAST_B) begin
                byte_n       = '0;
                reg_rd_start = 1'b1;
                word_n       = reg_rdata;
              end else begin
                byte_n = byte_q + 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      // R11: the pull-low enable only moves on a falling SCL
      unique case (ph_q)
        PH_CTRL, PH_WADDR, PH_WDATA: oe_n = (bit_q == 4'd8) && ackgo_q;
        PH_RDATA: begin
          if (bit_q != 4'd8) begin
            oe_n   = ~word_q[DATA_W-1];
            word_n = {word_q[DATA_W-2:0], 1'b0};
          end else begin
            oe_n = 1'b0;
          end
        end
        default: oe_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ph_q <= PH_IDLE; bit_q <= '0; byte_q <= '0; sh_q <= '0;
      word_q <= '0; addr_q <= '0; oe_q <= 1'b0;
      ackgo_q <= 1'b0; rw_q <= 1'b0;
    end else begin
      ph_q <= ph_n; bit_q <= bit_n; byte_q <= byte_n; sh_q <= sh_n;
      word_q <= word_n; addr_q <= addr_n; oe_q <= oe_n;
      ackgo_q <= ackgo_n; rw_q <= rw_n;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = {word_q[DATA_W-9:0], byte_v};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({reg_wr, reg_rd_start, reg_rd_commit})); // R3
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(sda_oe) |-> !scl_s); // R11
  AST_COMMIT_ACKED: assert property (@(posedge clk) disable iff (!rst_sn)
    reg_rd_commit |-> (!sda_s && scl_s && ph_q == PH_RDATA)); // R8
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (ph_q == PH_SKIP) |-> (!sda_oe && !reg_wr && !reg_rd_commit)); // R2
  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_sn)
    stop_det |=> (!sda_oe && ph_q == PH_IDLE)); // R9
endmodule

// File: tb/tb_i2c_word_bridge.sv
module tb_i2c_word_bridge;
  localparam int CLK_P = 10;
  localparam int Q     = 6;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst_n, scl, sda_m, sda_bus, sda_oe;
  logic [7:0]  reg_addr;
  logic        reg_wr, reg_rd_start, reg_rd_commit;
  logic [31:0] reg_wdata, reg_rdata;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_word_bridge dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd_start(reg_rd_start), .reg_rdata(reg_rdata),
    .reg_rd_commit(reg_rd_commit));

  function automatic logic [31:0] init_val(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {8'hC0 ^ b, b, ~b, 8'h5A};
  endfunction

  // register bank model: 0xF0..0xFF clear on read commit
  logic [31:0] regs [256];
  logic [31:0] expv [256];
  logic        poke_en;
  logic [7:0]  poke_addr;
  logic [31:0] poke_val;
  int          wr_cnt, cmt_cnt;

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= init_val(i);
      wr_cnt  <= 0;
      cmt_cnt <= 0;
    end else begin
      if (reg_wr) begin
        regs[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end else if (reg_rd_commit) begin
        if (reg_addr >= 8'hF0) regs[reg_addr] <= 32'h0;
        cmt_cnt <= cmt_cnt + 1;
      end else if (poke_en) begin
        regs[poke_addr] <= poke_val;
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  logic [7:0]  cur_addr;
  logic [31:0] wbuf [4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] ev);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, ev);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tk(Q); scl = 1'b1; tk(2*Q); scl = 1'b0; tk(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q); b = sda_bus; tk(Q); scl = 1'b0; tk(Q);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q); sda_m = 1'b0; tk(Q); scl = 1'b0; tk(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tk(Q); scl = 1'b1; tk(Q); sda_m = 1'b1; tk(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic rd_byte(input logic ack_it, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(~ack_it);
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] v);
    poke_addr = a; poke_val = v; poke_en = 1'b1; tk(1); poke_en = 1'b0;
  endtask

  task automatic wr_words(input logic [7:0] a, input int n, input string req);
    logic ack, all;
    int w0;
    logic [7:0] aw;
    w0 = wr_cnt;
    i2c_start;
    wr_byte({SLV, 1'b0}, ack); all = ack;
    wr_byte(a, ack); all &= ack;
    for (int w = 0; w < n; w++)
      for (int k = 0; k < 4; k++) begin
        wr_byte(wbuf[w][31-8*k -: 8], ack);
        all &= ack;
      end
    i2c_stop;
    for (int w = 0; w < n; w++) begin
      aw = a + w[7:0];
      expv[aw] = wbuf[w];
    end
    chk(all, {req, " every write byte acked"}, {31'd0, all}, 32'd1);
    chk(wr_cnt - w0 == n, {req, " write strobe count"}, wr_cnt - w0, n);
    cur_addr = a + n[7:0];
  endtask

  task automatic read_check(input logic [7:0] a, input bit use_addr, input int n, input string req);
    logic ack, all;
    logic [7:0] b, aw;
    logic [31:0] got;
    int c0;
    c0 = cmt_cnt;
    all = 1'b1;
    i2c_start;
    if (use_addr) begin
      wr_byte({SLV, 1'b0}, ack); all &= ack;
      wr_byte(a, ack); all &= ack;
      i2c_start;
    end
    wr_byte({SLV, 1'b1}, ack); all &= ack;
    chk(all, {req, " read setup acked"}, {31'd0, all}, 32'd1);
    for (int w = 0; w < n; w++) begin
      aw = a + w[7:0];
      got = '0;
      for (int k = 0; k < 4; k++) begin
        rd_byte(!(w == n-1 && k == 3), b);
        got = {got[23:0], b};
      end
      chk(got == expv[aw], {req, " read data"}, got, expv[aw]);
      if (aw >= 8'hF0) expv[aw] = 32'h0;
    end
    i2c_stop;
    chk(cmt_cnt - c0 == n, {req, " commit count"}, cmt_cnt - c0, n);
    cur_addr = a + n[7:0];
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary;
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [31:0] got, old;
    int w0, c0, dummy;
    dummy = $urandom(32'h1BAD5EED);
    for (int i = 0; i < 256; i++) expv[i] = init_val(i);
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; poke_en = 1'b0;
    poke_addr = '0; poke_val = '0; cur_addr = '0;
    tk(5); rst_n = 1'b1; tk(6);

    // R1: idle after reset
    chk(!sda_oe && !reg_wr && !reg_rd_start && !reg_rd_commit, "R1 reset outputs",
        {28'd0, sda_oe, reg_wr, reg_rd_start, reg_rd_commit}, 32'd0);

    // R2: foreign address, both directions
    w0 = wr_cnt;
    i2c_start;
    wr_byte({7'h2B, 1'b0}, ack);
    chk(!ack, "R2 foreign write address nacked", {31'd0, ack}, 32'd0);
    wr_byte(8'h05, ack);
    chk(!ack, "R2 byte after foreign address nacked", {31'd0, ack}, 32'd0);
    for (int k = 0; k < 4; k++) wr_byte(8'h00, ack);
    i2c_stop;
    chk(wr_cnt == w0, "R2 no write after foreign address", wr_cnt, w0);
    i2c_start;
    wr_byte({7'h2B, 1'b1}, ack);
    chk(!ack && !sda_oe, "R2 foreign read address nacked", {30'd0, ack, sda_oe}, 32'd0);
    i2c_stop;

    // R3 R4 R6: single write, read back, then follow-on read with no address
    wbuf[0] = 32'hDEADBEEF;
    wr_words(8'h20, 1, "R3");
    chk(cur_addr == 8'h21, "R4 expected address after single write", cur_addr, 8'h21);
    read_check(8'h21, 1'b0, 1, "R4 follow-on read");
    read_check(8'h20, 1'b1, 1, "R6");

    // R5: partial write cut by stop
    w0 = wr_cnt;
    i2c_start;
    wr_byte({SLV, 1'b0}, ack); wr_byte(8'h30, ack);
    wr_byte(8'h11, ack); wr_byte(8'h22, ack);
    i2c_stop;
    chk(wr_cnt == w0, "R5 stop drops partial word", wr_cnt, w0);
    read_check(8'h30, 1'b1, 1, "R5 register untouched after stop");

    // R5: partial write cut by repeated start, address must stay 0x31
    w0 = wr_cnt;
    i2c_start;
    wr_byte({SLV, 1'b0}, ack); wr_byte(8'h31, ack);
    wr_byte(8'h33, ack); wr_byte(8'h44, ack); wr_byte(8'h55, ack);
    i2c_start;
    wr_byte({SLV, 1'b1}, ack);
    got = '0;
    for (int k = 0; k < 4; k++) begin
      rd_byte(k != 3, b);
      got = {got[23:0], b};
    end
    i2c_stop;
    chk(wr_cnt == w0, "R5 repeated start drops partial word", wr_cnt, w0);
    chk(got == expv[8'h31], "R5 address unchanged by partial word", got, expv[8'h31]);

    // R4 R10: burst write and burst read across 0xFF -> 0x00
    wbuf[0] = 32'h01020304; wbuf[1] = 32'hA1B2C3D4; wbuf[2] = 32'h0F0E0D0C;
    wr_words(8'hFE, 3, "R4 wrap write");
    chk(cur_addr == 8'h01, "R4 address after wrap", cur_addr, 8'h01);
    read_check(8'h01, 1'b0, 1, "R4 follow-on after wrap");
    poke(8'hFE, 32'h01020304); poke(8'hFF, 32'hA1B2C3D4);
    read_check(8'hFE, 1'b1, 3, "R10 wrap burst read");

    // R8: clear-on-read register returns original in all bytes, then zero
    read_check(8'hF4, 1'b1, 1, "R8 original value with commit");
    read_check(8'hF4, 1'b1, 1, "R8 cleared after commit");

    // R9: nack on first byte, then nack on third byte, no commit
    c0 = cmt_cnt;
    i2c_start;
    wr_byte({SLV, 1'b0}, ack); wr_byte(8'hF5, ack); i2c_start;
    wr_byte({SLV, 1'b1}, ack);
    rd_byte(1'b0, b);
    tk(2);
    chk(!sda_oe, "R9 SDA released after nack", {31'd0, sda_oe}, 32'd0);
    i2c_stop;
    chk(cmt_cnt == c0, "R9 no commit on first-byte nack", cmt_cnt, c0);
    i2c_start;
    wr_byte({SLV, 1'b0}, ack); wr_byte(8'hF5, ack); i2c_start;
    wr_byte({SLV, 1'b1}, ack);
    rd_byte(1'b1, b); rd_byte(1'b1, b); rd_byte(1'b0, b);
    i2c_stop;
    chk(cmt_cnt == c0, "R9 no commit on third-byte nack", cmt_cnt, c0);
    read_check(8'hF5, 1'b1, 1, "R9 register kept after aborted reads");

    // R7: value changes after the latch do not reach the bytes of the word
    old = expv[8'h40];
    i2c_start;
    wr_byte({SLV, 1'b0}, ack); wr_byte(8'h40, ack); i2c_start;
    wr_byte({SLV, 1'b1}, ack);
    rd_byte(1'b1, b); got = {24'd0, b};
    poke(8'h40, 32'h13572468);
    for (int k = 1; k < 4; k++) begin
      rd_byte(k != 3, b);
      got = {got[23:0], b};
    end
    i2c_stop;
    chk(got == old, "R7 snapshot held across update", got, old);
    expv[8'h40] = 32'h13572468;
    read_check(8'h40, 1'b1, 1, "R7 new value on next read");

    // random bursts
    for (int it = 0; it < 10; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom % 256);
      n = 1 + int'($urandom % 3);
      for (int w = 0; w < n; w++) wbuf[w] = $urandom;
      wr_words(a, n, "R3 random burst write");
      read_check(cur_addr, 1'b0, 1, "R4 random follow-on read");
      read_check(a, 1'b1, n, "R10 random burst read");
    end

    summary;
    $finish;
  end
endmodule